// File: doc/BRIEF.md
# I2C Combined Write-Then-Read Master

This block is a single-master I2C controller that carries out a complete bus transaction from one command. A command names a 7-bit target address, how many bytes to write and how many bytes to read. The block issues a start, sends the address with the direction bit, streams the write bytes it pulls through a ready/valid byte port, and then, when a read is requested, joins a read phase with a repeated start. Read bytes leave through a one-cycle valid strobe. One stop ends every transaction, whether it succeeded or was cut short by a missing acknowledge.

Both bus lines are open-drain. The block drives a line low only by asserting its drive-low output. A high level is a released line, pulled up outside the block. All bus timing is built from whole multiples of one base delay D, given in system clock cycles on a runtime input. Every step of the bus sequence lasts D, 2D or 8D.

A write length of zero skips the write phase, so the first address goes out with the read direction. Zero for both lengths gives an address-only probe. Clock stretching, arbitration and 10-bit addressing are not handled.

Top module: `i2c_xact_master`

## Requirements
- R1: Out of reset and whenever idle, both drive-low outputs are 0, busy is 0 and cmd_ready is 1.
- R2: A start condition is four steps of D cycles each: SDA released (SCL unchanged), then SCL released, then SDA driven low, then SCL driven low. A base delay input of 0 behaves exactly like 1.
- R3: Each transmitted bit goes out MSB first. SDA takes the bit level while SCL is low for D cycles, then SCL is released for 2D cycles and driven low again for D cycles.
- R4: After 8 transmitted bits, SDA is released and SCL is released for 2D cycles. SDA is sampled on the last of those cycles (0 is ACK, 1 is NACK). SCL is then held low for D cycles.
- R5: The write phase sends address with direction bit 0, then each payload byte. Before each payload byte the block raises wr_ready with SCL low and takes wr_data on the first cycle that wr_valid is 1. While wr_valid stays 0 the bus holds still.
- R6: When the write phase completed with every byte acknowledged and the read length is nonzero, a repeated start follows, then the address with direction bit 1. With a write length of 0, the first start is followed directly by the address with direction bit 1.
- R7: Each read bit is SCL low for D cycles with SDA released, then SCL released for 2D cycles with SDA sampled on the last cycle, MSB first. Each completed byte appears on rd_data with a one-cycle rd_valid while SCL is driven low. Every read byte except the last is followed by a master ACK: SDA low with SCL low D, SCL released 2D, SCL low D.
- R8: A NACK on any transmitted byte ends the transaction at once with a stop, and nack_err pulses in the same cycle as done.
- R9: A stop is SDA low with SCL low for D cycles, then SCL released for 2D cycles, then SDA released for an 8D bus-free time before the block returns to idle.
- R10: busy is 1 from the cycle after the accepting edge until the bus-free time ends. done then pulses for exactly one cycle with busy 0, and rd_count holds the number of bytes read in that transaction.
- R11: A command presented while busy is ignored: cmd_ready is 0 and the bus sequence in progress is unaffected.
- R12: With both lengths zero, the block sends start, address with direction bit 0, the acknowledge slot, and a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted on a cycle where both are 1 |
| cmd_addr | input | 7 | Target address |
| cmd_wr_len | input | LEN_W | Number of payload bytes to write |
| cmd_rd_len | input | LEN_W | Number of bytes to read |
| base_dly | input | DLY_W | Base delay D in clock cycles, 0 treated as 1 |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Block is taking a payload byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_count | output | LEN_W | Bytes read in the current or last transaction |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nack_err | output | 1 | One-cycle pulse with done when a NACK aborted the transaction |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The main function is tried with a write-only transfer, a write joined to a two-byte read, a read-only transfer, and an address-only probe. Together these separate the repeated-start path from the direct read path and the no-payload path. NACKs are placed on the address, on a later payload byte and on the read address, which shows that each abort point leads straight to a stop with an error. Different base delays, including 0, show that every step scales with D. A stalled wr_valid and a command held active while busy show that neither disturbs the bus waveform.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // transaction phase of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_TXBIT,
        PH_TXACK,
        PH_FETCH,
        PH_RXBIT,
        PH_MACK,
        PH_STOP
    } phase_e;

    // length of a bus step in units of the base delay
    typedef enum logic [1:0] {
        SPAN_1D,
        SPAN_2D,
        SPAN_8D
    } span_e;

endpackage

// File: rtl/i2cm_step_timer.sv
module i2cm_step_timer
    import i2cm_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  span_e            span,
    input  logic [DLY_W-1:0] dly,
    output logic             expired
);
    localparam int CNT_W = DLY_W + 3;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [DLY_W-1:0] d_eff;
    logic [1:0]       shamt;
    logic [CNT_W-1:0] steps;

    always_comb begin
        d_eff = (dly == '0) ? DLY_W'(1) : dly;
        case (span)
            SPAN_2D: shamt = 2'd1;
            SPAN_8D: shamt = 2'd3;
            default: shamt = 2'd0;
        endcase
        steps = {3'b000, d_eff} << shamt;
        if (load)
            cnt_d = steps - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2cm_bit_shifter.sv
module i2cm_bit_shifter #(
    parameter int HOLD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              shift,
    input  logic              shift_in,
    output logic [HOLD_W-1:0] hold
);
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] hold_d;

    always_comb begin
        if (load)       hold_d = load_val;
        else if (shift) hold_d = {hold_q[HOLD_W-2:0], shift_in};
        else            hold_d = hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold = hold_q;
endmodule

// File: rtl/i2c_xact_master.sv
module i2c_xact_master
    import i2cm_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [6:0]       cmd_addr,
    input  logic [LEN_W-1:0] cmd_wr_len,
    input  logic [LEN_W-1:0] cmd_rd_len,
    input  logic [DLY_W-1:0] base_dly,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [LEN_W-1:0] rd_count,
    output logic             busy,
    output logic             done,
    output logic             nack_err,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    input  logic             sda_in
);
    localparam int BYTE_W = 8;
    localparam int HOLD_W = BYTE_W - 1;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);

    typedef struct packed {
        phase_e             ph;
        logic [1:0]         step;
        logic [BIT_W-1:0]   bitn;
        logic [LEN_W-1:0]   wr_left;
        logic [LEN_W-1:0]   rd_left;
        logic [LEN_W-1:0]   rd_cnt;
        logic [6:0]         addr;
        logic               rd_ph;
        logic               nack;
        logic               scl_lo;
        logic               sda_lo;
        logic               rdv;
        logic [BYTE_W-1:0]  rdd;
        logic               done;
        logic               err;
    } ctl_t;

    ctl_t q, n;

    logic              t_load;
    span_e             t_span;
    logic              t_exp;
    logic              s_load;
    logic [HOLD_W-1:0] s_val;
    logic              s_shift;
    logic              s_in;
    logic [HOLD_W-1:0] s_hold;

    i2cm_step_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .span    (t_span),
        .dly     (base_dly),
        .expired (t_exp)
    );

    i2cm_bit_shifter #(.HOLD_W(HOLD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (s_load),
        .load_val (s_val),
        .shift    (s_shift),
        .shift_in (s_in),
        .hold     (s_hold)
    );

    always_comb begin
        n        = q;
        n.rdv    = 1'b0;
        n.done   = 1'b0;
        n.err    = 1'b0;
        t_load   = 1'b0;
        t_span   = SPAN_1D;
        s_load   = 1'b0;
        s_val    = '0;
        s_shift  = 1'b0;
        s_in     = 1'b0;
        wr_ready = 1'b0;
        cmd_ready = (q.ph == PH_IDLE);

        case (q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    n.ph      = PH_START;
                    n.step    = 2'd0;
                    n.addr    = cmd_addr;
                    n.wr_left = cmd_wr_len;
                    n.rd_left = cmd_rd_len;
                    n.rd_cnt  = '0;
                    n.nack    = 1'b0;
                    n.rd_ph   = (cmd_wr_len == '0) && (cmd_rd_len != '0);
                    n.sda_lo  = 1'b0;
                    t_load    = 1'b1;
                end
            end
            PH_START: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    case (q.step)
                        2'd0: begin n.scl_lo = 1'b0; n.step = 2'd1; end
                        2'd1: begin n.sda_lo = 1'b1; n.step = 2'd2; end
                        2'd2: begin n.scl_lo = 1'b1; n.step = 2'd3; end
                        default: begin
                            s_load = 1'b1;
                            s_val  = {q.addr[5:0], q.rd_ph};
                            n.ph   = PH_TXBIT;
                            n.step = 2'd0;
                            n.bitn = LAST_BIT;
                            n.sda_lo = ~q.addr[6];
                        end
                    endcase
                end
            end
            PH_TXBIT: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    case (q.step)
                        2'd0: begin n.scl_lo = 1'b0; n.step = 2'd1; t_span = SPAN_2D; end
                        2'd1: begin n.scl_lo = 1'b1; n.step = 2'd2; end
                        default: begin
                            n.step = 2'd0;
                            if (q.bitn != '0) begin
                                s_shift  = 1'b1;
                                n.bitn   = q.bitn - BIT_W'(1);
                                n.sda_lo = ~s_hold[HOLD_W-1];
                            end else begin
                                n.ph     = PH_TXACK;
                                n.scl_lo = 1'b0;
                                n.sda_lo = 1'b0;
                                t_span   = SPAN_2D;
                            end
                        end
                    endcase
                end
            end
            PH_TXACK: begin
                if (t_exp) begin
                    if (q.step == 2'd0) begin
                        n.nack   = sda_in;
                        n.scl_lo = 1'b1;
                        n.step   = 2'd1;
                        t_load   = 1'b1;
                    end else begin
                        n.step = 2'd0;
                        if (q.nack) begin
                            n.ph = PH_STOP; n.sda_lo = 1'b1; t_load = 1'b1;
                        end else if (q.rd_ph) begin
                            n.ph = PH_RXBIT; n.bitn = LAST_BIT; t_load = 1'b1;
                        end else if (q.wr_left != '0) begin
                            n.ph = PH_FETCH;
                        end else if (q.rd_left != '0) begin
                            n.ph = PH_START; n.rd_ph = 1'b1; t_load = 1'b1;
                        end else begin
                            n.ph = PH_STOP; n.sda_lo = 1'b1; t_load = 1'b1;
                        end
                    end
                end
            end
            PH_FETCH: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    s_load    = 1'b1;
                    s_val     = wr_data[HOLD_W-1:0];
                    n.wr_left = q.wr_left - ONE_LEN;
                    n.ph      = PH_TXBIT;
                    n.step    = 2'd0;
                    n.bitn    = LAST_BIT;
                    n.sda_lo  = ~wr_data[BYTE_W-1];
                    t_load    = 1'b1;
                end
            end
            PH_RXBIT: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (q.step == 2'd0) begin
                        n.scl_lo = 1'b0; n.step = 2'd1; t_span = SPAN_2D;
                    end else begin
                        s_shift  = 1'b1;
                        s_in     = sda_in;
                        n.step   = 2'd0;
                        n.scl_lo = 1'b1;
                        if (q.bitn != '0) begin
                            n.bitn = q.bitn - BIT_W'(1);
                        end else begin
                            n.rdv     = 1'b1;
                            n.rdd     = {s_hold, sda_in};
                            n.rd_cnt  = q.rd_cnt + ONE_LEN;
                            n.rd_left = q.rd_left - ONE_LEN;
                            n.sda_lo  = 1'b1;
                            n.ph      = (q.rd_left > ONE_LEN) ? PH_MACK : PH_STOP;
                        end
                    end
                end
            end
            PH_MACK: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    case (q.step)
                        2'd0: begin n.scl_lo = 1'b0; n.step = 2'd1; t_span = SPAN_2D; end
                        2'd1: begin n.scl_lo = 1'b1; n.step = 2'd2; end
                        default: begin
                            n.ph = PH_RXBIT; n.step = 2'd0;
                            n.sda_lo = 1'b0; n.bitn = LAST_BIT;
                        end
                    endcase
                end
            end
            PH_STOP: begin
                if (t_exp) begin
                    case (q.step)
                        2'd0: begin
                            n.scl_lo = 1'b0; n.step = 2'd1;
                            t_load = 1'b1; t_span = SPAN_2D;
                        end
                        2'd1: begin
                            n.sda_lo = 1'b0; n.step = 2'd2;
                            t_load = 1'b1; t_span = SPAN_8D;
                        end
                        default: begin
                            n.ph   = PH_IDLE;
                            n.step = 2'd0;
                            n.done = 1'b1;
                            n.err  = q.nack;
                        end
                    endcase
                end
            end
            default: n.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign busy          = (q.ph != PH_IDLE);
    assign done          = q.done;
    assign nack_err      = q.err;
    assign rd_valid      = q.rdv;
    assign rd_data       = q.rdd;
    assign rd_count      = q.rd_cnt;
    assign scl_drive_low = q.scl_lo;
    assign sda_drive_low = q.sda_lo;
endmodule

// File: rtl/i2cm_xact_chk.sv
module i2cm_xact_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic nack_err,
    input logic wr_ready,
    input logic rd_valid,
    input logic scl_drive_low,
    input logic sda_drive_low
);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_err |-> done);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R5
    fetch_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> scl_drive_low);

    // R7
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && scl_drive_low));
endmodule

bind i2c_xact_master i2cm_xact_chk u_xact_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .busy          (busy),
    .done          (done),
    .nack_err      (nack_err),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
);

// File: tb/test_i2c_xact_master.sv
`timescale 1ns/1ps
module test_i2c_xact_master;
    localparam int LEN_W = 8;
    localparam int DLY_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [6:0]       cmd_addr = '0;
    logic [LEN_W-1:0] cmd_wr_len = '0;
    logic [LEN_W-1:0] cmd_rd_len = '0;
    logic [DLY_W-1:0] base_dly = '0;
    logic [7:0]       wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic [LEN_W-1:0] rd_count;
    logic             busy, done, nack_err;
    logic             scl_drive_low, sda_drive_low;
    logic             slave_sda = 1'b1;
    logic             sda_in;

    assign sda_in = slave_sda & ~sda_drive_low;

    always #10 clk = ~clk;

    i2c_xact_master #(.LEN_W(LEN_W), .DLY_W(DLY_W)) i_i2c_xact_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_wr_len(cmd_wr_len), .cmd_rd_len(cmd_rd_len),
        .base_dly(base_dly), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_count(rd_count), .busy(busy), .done(done), .nack_err(nack_err),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_in)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // expected bus schedule: one entry per step
    int    e_scl[$], e_sda[$], e_len[$], e_slv[$], e_rd[$], e_fetch[$];
    string e_tag[$];
    int    pend_rd = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic seg(input int scl, input int sda, input int len, input int slv,
                       input int fetch, input string tag);
        e_scl.push_back(scl); e_sda.push_back(sda); e_len.push_back(len);
        e_slv.push_back(slv); e_rd.push_back(pend_rd); e_fetch.push_back(fetch);
        e_tag.push_back(tag);
        pend_rd = -1;
    endtask

    task automatic add_start(input int scl_prev, input int d, input string tag);
        seg(scl_prev, 0, d, 1, 0, tag);
        seg(0, 0, d, 1, 0, tag);
        seg(0, 1, d, 1, 0, tag);
        seg(1, 1, d, 1, 0, tag);
    endtask

    task automatic add_tx(input logic [7:0] b, input bit ack, input int d);
        for (int i = 7; i >= 0; i--) begin
            seg(1, b[i] ? 0 : 1, d, 1, 0, "R3");
            seg(0, b[i] ? 0 : 1, 2 * d, 1, 0, "R3");
            seg(1, b[i] ? 0 : 1, d, 1, 0, "R3");
        end
        seg(0, 0, 2 * d, ack ? 0 : 1, 0, "R4");
        seg(1, 0, d, 1, 0, "R4");
    endtask

    task automatic add_rx(input logic [7:0] v, input bit last, input int d);
        for (int i = 7; i >= 0; i--) begin
            seg(1, 0, d, 1, 0, "R7");
            seg(0, 0, 2 * d, int'(v[i]), 0, "R7");
        end
        pend_rd = int'(v);
        if (!last) begin
            seg(1, 1, d, 1, 0, "R7");
            seg(0, 1, 2 * d, 1, 0, "R7");
            seg(1, 1, d, 1, 0, "R7");
        end
    endtask

    task automatic add_stop(input int d);
        seg(1, 1, d, 1, 0, "R9");
        seg(0, 1, 2 * d, 1, 0, "R9");
        seg(0, 0, 8 * d, 1, 0, "R9");
    endtask

    function automatic logic [7:0] pay(input int i);
        return 8'(8'hA5 ^ (i * 37));
    endfunction

    function automatic logic [7:0] rdv(input int i);
        return 8'(8'h3C + i * 8'h51);
    endfunction

    // nack_at: index of transmitted byte (0 = first address) that gets NACK, -1 none
    task automatic run(input logic [6:0] addr, input int wlen, input int rlen,
                       input int dly, input int nack_at, input int stall,
                       input bit junk, input string tag);
        int  d;
        int  bidx;
        bit  nk;
        int  rdn;
        int  pi;
        bit  ack;
        d = (dly == 0) ? 1 : dly;
        e_scl.delete(); e_sda.delete(); e_len.delete(); e_slv.delete();
        e_rd.delete(); e_fetch.delete(); e_tag.delete();
        pend_rd = -1; nk = 0; rdn = 0; bidx = 0;

        add_start(0, d, "R2");
        ack = (nack_at != bidx);
        add_tx({addr, 1'((wlen == 0) && (rlen != 0))}, ack, d);
        bidx++;
        if (!ack) nk = 1;
        if (!nk && wlen > 0) begin
            for (int i = 0; i < wlen; i++) begin
                seg(1, 0, 1 + stall, 1, 1, "R5");
                ack = (nack_at != bidx);
                add_tx(pay(i), ack, d);
                bidx++;
                if (!ack) begin nk = 1; break; end
            end
            if (!nk && rlen > 0) begin
                add_start(1, d, "R6");
                ack = (nack_at != bidx);
                add_tx({addr, 1'b1}, ack, d);
                bidx++;
                if (!ack) nk = 1;
            end
        end
        if (!nk && rlen > 0) begin
            for (int i = 0; i < rlen; i++) begin
                add_rx(rdv(i), i == rlen - 1, d);
                rdn++;
            end
        end
        add_stop(d);

        @(negedge clk);
        chk(cmd_ready == 1'b1, {tag, " R1 ready"}, int'(cmd_ready), 1);
        cmd_valid  = 1'b1;
        cmd_addr   = addr;
        cmd_wr_len = LEN_W'(wlen);
        cmd_rd_len = LEN_W'(rlen);
        base_dly   = DLY_W'(dly);
        @(posedge clk);
        pi = 0;
        for (int s = 0; s < e_scl.size(); s++) begin
            for (int k = 0; k < e_len[s]; k++) begin
                @(negedge clk);
                if (junk) begin
                    cmd_addr   = 7'(7'h55 ^ k);
                    cmd_wr_len = LEN_W'(k);
                end else begin
                    cmd_valid = 1'b0;
                end
                slave_sda = e_slv[s][0];
                if (e_fetch[s] != 0) begin
                    wr_valid = (k >= stall);
                    wr_data  = pay(pi);
                end else begin
                    wr_valid = 1'b0;
                end
                chk(int'(scl_drive_low) == e_scl[s], {tag, " ", e_tag[s], " scl"},
                    int'(scl_drive_low), e_scl[s]);
                chk(int'(sda_drive_low) == e_sda[s], {tag, " ", e_tag[s], " sda"},
                    int'(sda_drive_low), e_sda[s]);
                chk(busy == 1'b1, {tag, " R10 busy"}, int'(busy), 1);
                chk(cmd_ready == 1'b0, {tag, " R11 ready while busy"}, int'(cmd_ready), 0);
                chk(int'(wr_ready) == e_fetch[s], {tag, " R5 wr_ready"},
                    int'(wr_ready), e_fetch[s]);
                chk(int'(rd_valid) == int'(k == 0 && e_rd[s] >= 0), {tag, " R7 rd_valid"},
                    int'(rd_valid), int'(k == 0 && e_rd[s] >= 0));
                if (k == 0 && e_rd[s] >= 0)
                    chk(int'(rd_data) == e_rd[s], {tag, " R7 rd_data"},
                        int'(rd_data), e_rd[s]);
            end
            if (e_fetch[s] != 0) pi++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        wr_valid  = 1'b0;
        slave_sda = 1'b1;
        chk(done == 1'b1, {tag, " R10 done"}, int'(done), 1);
        chk(busy == 1'b0, {tag, " R10 busy end"}, int'(busy), 0);
        chk(int'(nack_err) == int'(nk), {tag, " R8 nack_err"}, int'(nack_err), int'(nk));
        chk(int'(rd_count) == rdn, {tag, " R10 rd_count"}, int'(rd_count), rdn);
        chk(!scl_drive_low && !sda_drive_low, {tag, " R1 lines released"},
            int'({scl_drive_low, sda_drive_low}), 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R10 done one cycle"}, int'(done), 0);
        chk(busy == 1'b0, {tag, " R11 no late accept"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(cmd_ready == 1'b1, "R1 reset ready", int'(cmd_ready), 1);
        chk(!scl_drive_low && !sda_drive_low, "R1 reset lines",
            int'({scl_drive_low, sda_drive_low}), 0);
        chk(done == 1'b0 && rd_valid == 1'b0, "R1 reset strobes",
            int'({done, rd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(7'h1A, 2, 0, 2, -1, 0, 0, "T1 write R5");
        run(7'h2B, 1, 2, 3, -1, 0, 0, "T2 write+read R6");
        run(7'h45, 0, 1, 1, -1, 0, 0, "T3 read only R6");
        run(7'h33, 2, 1, 2,  0, 0, 0, "T4 addr nack R8");
        run(7'h11, 3, 0, 1,  2, 0, 0, "T5 payload nack R8");
        run(7'h7E, 1, 1, 1,  2, 0, 0, "T6 read addr nack R8");
        run(7'h09, 0, 0, 0, -1, 0, 0, "T7 probe d0 R12 R2");
        run(7'h60, 2, 0, 1, -1, 3, 0, "T8 stall R5");
        run(7'h25, 1, 3, 1, -1, 0, 1, "T9 busy cmd R11");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule